// File: doc/BRIEF.md
# Crosspoint Routing Control Register Bank

This block holds the routing and mode settings for a video crosspoint with twelve inputs and nine outputs. A host programs it over a two-wire serial bus. The block acts only as a target, and only for writes. It samples the bus clock and data lines with a fast system clock and answers to one of two device addresses, chosen by a strap pin. In each transfer the host sends a register index byte and then one or more data bytes.

Each of the nine outputs has its own register, which holds an enable, a gain code and an input select code. The block decodes these into control buses:

- a one-hot select per output, which is all zero when the output is powered down or has no valid input;
- a high-impedance flag per output;
- the gain code per output.

A separate pair of registers holds the clamp/bias mode for each of the twelve inputs. The analog switching, gain and clamp circuits sit outside the block and read these buses.

Top module: `xbarCtrlBank`

## Requirements
- R1: The block acknowledges the address byte 0x06 when `addrSel` is 0 and the address byte 0x86 when `addrSel` is 1. Bit 0 of the address byte is the direction bit, with 0 meaning write.
- R2: The block does not acknowledge an address byte that does not match, or that carries the read direction (bit 0 = 1). It then ignores the bus until the next START: it acknowledges no byte and changes no register.
- R3: Register index n (0x01 to 0x09) controls output n. Data bit 7 is the enable (1 = on). Bits 6:5 are the gain code, which appears on `outGain[2(n-1)+1 : 2(n-1)]` (00 = 6 dB up to 11 = 9 dB). Bits 4:0 are the select code.
- R4: A select code k from 1 to 12 asserts `outSelect[12(n-1)+k-1]` while output n is enabled. Code 0 and codes 13 to 31 assert no select bit for that output.
- R5: When an output's enable bit is 0, all of its select bits are 0 and `outHiZ` for that output is 1, whatever select code is stored. When the enable bit is 1, `outHiZ` is 0.
- R6: Several outputs may select the same input at the same time. Each output asserts at most one select bit.
- R7: Register 0x1D bits 7:0 set `clampMode[7:0]`, the modes of inputs 8 to 1. Register 0x1E bits 3:0 set `clampMode[11:8]`, the modes of inputs 12 to 9. Bits 7:4 of 0x1E are ignored. A mode bit of 1 selects clamp and 0 selects bias.
- R8: After reset every register is zero: every enable and select bit is 0, every gain code is 0, `clampMode` is 0, every `outHiZ` bit is 1, and `sdaDriveLow` is 0.
- R9: A write to any register index other than 0x01 to 0x09, 0x1D and 0x1E is acknowledged and changes no output.
- R10: A repeated START discards any partly received byte. The byte that follows it is treated as a new address byte.
- R11: A STOP ends the transaction and discards any partly received byte. Bytes clocked after a STOP and before the next START are neither acknowledged nor written.
- R12: Each further data byte in the same transaction is acknowledged and rewrites the same register. The register index does not advance.
- R13: For each accepted byte, the block pulls SDA low (`sdaDriveLow` = 1) only after the SCL falling edge that ends that byte's eighth bit. It releases SDA after the next SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 MHz |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial bus clock line, sampled |
| sdaIn | input | 1 | Serial bus data line, sampled |
| addrSel | input | 1 | Address strap: 0 selects 0x06, 1 selects 0x86 |
| sdaDriveLow | output | 1 | 1 pulls SDA low to acknowledge (open-drain enable) |
| outEnable | output | 9 | Enable bit of each output |
| outHiZ | output | 9 | High-impedance flag of each output |
| outGain | output | 18 | 2-bit gain code per output, output n at bits 2n-1:2n-2 |
| outSelect | output | 108 | One-hot input select, 12 bits per output |
| clampMode | output | 12 | Per-input mode, bit k-1 for input k, 1 = clamp |

## Verification
A corrupted register bit does not stay hidden. It shows on a decoded bus no later than the cycle after the strobe that writes the register. It shows as a wrong gain, a missing or extra select bit, or a stale high-impedance flag. A sequencer in the wrong state shows at the bus within one bit period, as an acknowledge in the wrong slot or a missing one. The bench therefore compares every decoded bus against a behavioural model on every clock outside write windows, and samples the acknowledge in each ninth clock.

// File: rtl/xbarCtrlPkg.sv
package xbarCtrlPkg;
  // One register write from the bus sequencer to the register file
  typedef struct packed {
    logic       wr;
    logic [7:0] addr;
    logic [7:0] data;
  } regWrStrobe_t;
endpackage

// File: rtl/xbarI2cTarget.sv
module xbarI2cTarget
  import xbarCtrlPkg::*;
#(
  parameter int         SYNC_STAGES   = 2,
  parameter logic [6:0] DEV_ADDR_BASE = 7'h03,
  parameter int         ADDR_SEL_BIT  = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic         addrSel,
  output logic         sdaDriveLow,
  output regWrStrobe_t wrStb
);
  typedef enum logic [1:0] {ST_IDLE, ST_RECV, ST_ACK} tgtState_t;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startCond, stopCond;
  tgtState_t state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg, subAddr;
  logic [1:0] byteIdx;
  logic ackDrive;
  logic [6:0] devAddr;
  logic [7:0] devByte;

  always_comb begin
    devAddr = DEV_ADDR_BASE;
    devAddr[ADDR_SEL_BIT] = addrSel;
    devByte = {devAddr, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS      = sclPipe[SYNC_STAGES-1];
  assign sdaS      = sdaPipe[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startCond = sclS & sclD & sdaD & ~sdaS;
  assign stopCond  = sclS & sclD & ~sdaD & sdaS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      shiftReg <= '0;
      subAddr  <= '0;
      byteIdx  <= '0;
      ackDrive <= 1'b0;
      wrStb    <= '0;
    end else begin
      wrStb.wr <= 1'b0;
      if (startCond) begin
        state    <= ST_RECV;
        bitCnt   <= '0;
        byteIdx  <= '0;
        ackDrive <= 1'b0;
      end else if (stopCond) begin
        state    <= ST_IDLE;
        ackDrive <= 1'b0;
      end else begin
        unique case (state)
          ST_RECV: begin
            if (sclRise && bitCnt < 4'd8) begin
              shiftReg <= {shiftReg[6:0], sdaS};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              unique case (byteIdx)
                2'd0: begin
                  if (shiftReg == devByte) begin
                    ackDrive <= 1'b1;
                    state    <= ST_ACK;
                    byteIdx  <= 2'd1;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                2'd1: begin
                  subAddr  <= shiftReg;
                  ackDrive <= 1'b1;
                  state    <= ST_ACK;
                  byteIdx  <= 2'd2;
                end
                default: begin
                  wrStb    <= '{wr: 1'b1, addr: subAddr, data: shiftReg};
                  ackDrive <= 1'b1;
                  state    <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              ackDrive <= 1'b0;
              state    <= ST_RECV;
              bitCnt   <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaDriveLow = ackDrive;

  // R13
  ack_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> $past(sclFall));
  // R13
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackDrive) |-> $past(sclFall || startCond || stopCond));
  // R11
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopCond && !startCond |=> state == ST_IDLE && !ackDrive);
  // R2
  strobe_after_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb.wr |-> $past(byteIdx) == 2'd2);
endmodule

// File: rtl/xbarRegFile.sv
module xbarRegFile
  import xbarCtrlPkg::*;
#(
  parameter int         NUM_OUT       = 9,
  parameter int         NUM_IN        = 12,
  parameter logic [7:0] CLAMP_LO_ADDR = 8'h1D,
  parameter logic [7:0] CLAMP_HI_ADDR = 8'h1E
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regWrStrobe_t          wrStb,
  output logic [NUM_OUT-1:0][7:0] cfgReg,
  output logic [NUM_IN-1:0]     clampMode
);
  localparam int HI_W = NUM_IN - 8;

  logic [7:0]      clampLo;
  logic [HI_W-1:0] clampHi;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    localparam logic [7:0] REG_ADDR = 8'(o + 1);
    always_ff @(posedge clk) begin
      if (!rstN) cfgReg[o] <= '0;
      else if (wrStb.wr && wrStb.addr == REG_ADDR) cfgReg[o] <= wrStb.data;
    end
    // R9
    cfg_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(cfgReg[o]) |-> $past(wrStb.wr && wrStb.addr == REG_ADDR));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clampLo <= '0;
      clampHi <= '0;
    end else if (wrStb.wr) begin
      if (wrStb.addr == CLAMP_LO_ADDR) clampLo <= wrStb.data;
      if (wrStb.addr == CLAMP_HI_ADDR) clampHi <= wrStb.data[HI_W-1:0];
    end
  end

  assign clampMode = {clampHi, clampLo};

  // R7
  clamp_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(clampMode) |-> $past(wrStb.wr &&
      (wrStb.addr == CLAMP_LO_ADDR || wrStb.addr == CLAMP_HI_ADDR)));
endmodule

// File: rtl/xbarRouteDecode.sv
module xbarRouteDecode #(
  parameter int NUM_OUT = 9,
  parameter int NUM_IN  = 12,
  parameter int SEL_W   = 5
) (
  input  logic [NUM_OUT-1:0][7:0] cfgReg,
  output logic [NUM_OUT-1:0]        outEnable,
  output logic [NUM_OUT-1:0]        outHiZ,
  output logic [2*NUM_OUT-1:0]      outGain,
  output logic [NUM_OUT*NUM_IN-1:0] outSelect
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [SEL_W-1:0] code;
    assign code             = cfgReg[o][SEL_W-1:0];
    assign outEnable[o]     = cfgReg[o][7];
    assign outHiZ[o]        = ~cfgReg[o][7];
    assign outGain[2*o +: 2] = cfgReg[o][6:5];
    for (genvar k = 0; k < NUM_IN; k++) begin : g_in
      assign outSelect[o*NUM_IN + k] = cfgReg[o][7] && (code == SEL_W'(k + 1));
    end
  end
endmodule

// File: rtl/xbarCtrlBank.sv
module xbarCtrlBank
  import xbarCtrlPkg::*;
#(
  parameter int         NUM_OUT       = 9,
  parameter int         NUM_IN        = 12,
  parameter int         SYNC_STAGES   = 2,
  parameter logic [6:0] DEV_ADDR_BASE = 7'h03
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  input  logic                      addrSel,
  output logic                      sdaDriveLow,
  output logic [NUM_OUT-1:0]        outEnable,
  output logic [NUM_OUT-1:0]        outHiZ,
  output logic [2*NUM_OUT-1:0]      outGain,
  output logic [NUM_OUT*NUM_IN-1:0] outSelect,
  output logic [NUM_IN-1:0]         clampMode
);
  regWrStrobe_t             wrStb;
  logic [NUM_OUT-1:0][7:0]  cfgReg;

  xbarI2cTarget #(
    .SYNC_STAGES(SYNC_STAGES), .DEV_ADDR_BASE(DEV_ADDR_BASE), .ADDR_SEL_BIT(6)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .sdaDriveLow(sdaDriveLow), .wrStb(wrStb)
  );

  xbarRegFile #(
    .NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN), .CLAMP_LO_ADDR(8'h1D), .CLAMP_HI_ADDR(8'h1E)
  ) uRegs (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .cfgReg(cfgReg), .clampMode(clampMode)
  );

  xbarRouteDecode #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN), .SEL_W(5)) uDec (
    .cfgReg(cfgReg), .outEnable(outEnable), .outHiZ(outHiZ),
    .outGain(outGain), .outSelect(outSelect)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk
    // R6
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(outSelect[o*NUM_IN +: NUM_IN]));
    // R5
    off_no_route_chk: assert property (@(posedge clk) disable iff (!rstN)
      outHiZ[o] |-> outSelect[o*NUM_IN +: NUM_IN] == '0 && !outEnable[o]);
  end
endmodule

// File: tb/xbarCtrlBank_test.sv
module xbarCtrlBank_test;
  localparam int Q = 10;

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1, addrSel = 1'b0;
  logic sdaDriveLow;
  logic [8:0] outEnable, outHiZ;
  logic [17:0] outGain;
  logic [107:0] outSelect;
  logic [11:0] clampMode;
  wire sdaLine = sdaM & ~sdaDriveLow;

  xbarCtrlBank uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaDriveLow(sdaDriveLow), .outEnable(outEnable), .outHiZ(outHiZ),
    .outGain(outGain), .outSelect(outSelect), .clampMode(clampMode)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  string curReq = "R8";
  bit busy = 1'b1;
  logic [7:0] refCfg [9];
  logic [7:0] refClampLo = '0;
  logic [3:0] refClampHi = '0;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural model compared on every clock outside write windows
  always @(posedge clk) begin : cmp
    logic [8:0] eEn, eZ;
    logic [17:0] eG;
    logic [107:0] eS;
    logic [11:0] eC;
    #5;
    if (!busy && rstN) begin
      eS = '0;
      for (int o = 0; o < 9; o++) begin
        eEn[o] = refCfg[o][7];
        eZ[o] = !refCfg[o][7];
        eG[2*o +: 2] = refCfg[o][6:5];
        for (int k = 0; k < 12; k++)
          if (refCfg[o][7] && int'(refCfg[o][4:0]) == k + 1) eS[12*o + k] = 1'b1;
      end
      eC = {refClampHi, refClampLo};
      chk({outEnable, outHiZ, outGain, outSelect, clampMode} == {eEn, eZ, eG, eS, eC},
          curReq, "per-clock outputs", {outEnable, outHiZ, outGain, outSelect, clampMode},
          {eEn, eZ, eG, eS, eC});
    end
  end

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask
  task automatic startC(); sdaM = 1; waitQ(); sclM = 1; waitQ(); sdaM = 0; waitQ(); sclM = 0; waitQ(); endtask
  task automatic stopC(); sdaM = 0; waitQ(); sclM = 1; waitQ(); sdaM = 1; waitQ(); endtask
  task automatic sendBit(bit b); sdaM = b; waitQ(); sclM = 1; waitQ(); waitQ(); sclM = 0; waitQ(); endtask

  task automatic sendByte(logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaM = 1; waitQ(); sclM = 1; waitQ();
    acked = !sdaLine;
    waitQ(); sclM = 0; waitQ();
  endtask

  task automatic modelWrite(logic [7:0] sub, logic [7:0] data);
    if (sub >= 8'h01 && sub <= 8'h09) refCfg[sub - 1] = data;
    else if (sub == 8'h1D) refClampLo = data;
    else if (sub == 8'h1E) refClampHi = data[3:0];
  endtask

  task automatic wrReg(logic [7:0] devB, logic [7:0] sub, logic [7:0] data, bit expAck, string req);
    bit a;
    curReq = req;
    startC();
    sendByte(devB, a); chk(a == expAck, req, "address ack", a, expAck);
    sendByte(sub, a);  chk(a == expAck, req, "index ack", a, expAck);
    busy = 1;
    sendByte(data, a); chk(a == expAck, req, "data ack", a, expAck);
    if (expAck) modelWrite(sub, data);
    busy = 0;
    stopC();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    bit a;
    logic [107:0] selSnap;
    for (int o = 0; o < 9; o++) refCfg[o] = '0;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    busy = 0;
    // R8 reset state
    chk(outEnable == '0 && outSelect == '0 && outGain == '0, "R8", "reset routing",
        {outEnable, outGain}, 0);
    chk(outHiZ == 9'h1FF && clampMode == '0 && !sdaDriveLow, "R8", "reset hiz/clamp",
        {outHiZ, clampMode, sdaDriveLow}, {9'h1FF, 12'h0, 1'b0});
    waitQ();

    // R3 fields: enable, gain 10, input 5 on output 3
    wrReg(8'h06, 8'h03, 8'hC5, 1, "R3");
    chk(outEnable[2] && outGain[5:4] == 2'b10 && outSelect[24 +: 12] == 12'h010, "R3",
        "output 3 fields", {outEnable[2], outGain[5:4], outSelect[24 +: 12]}, {1'b1, 2'b10, 12'h010});
    // R4 code 12, code 13, code 17, code 0
    wrReg(8'h06, 8'h01, 8'h8C, 1, "R4");
    chk(outSelect[11:0] == 12'h800, "R4", "code 12", outSelect[11:0], 12'h800);
    wrReg(8'h06, 8'h01, 8'h8D, 1, "R4");
    chk(outSelect[11:0] == 12'h000, "R4", "code 13", outSelect[11:0], 0);
    wrReg(8'h06, 8'h01, 8'h91, 1, "R4");
    chk(outSelect[11:0] == 12'h000 && outEnable[0], "R4", "code 17", outSelect[11:0], 0);
    wrReg(8'h06, 8'h02, 8'h80, 1, "R4");
    chk(outSelect[23:12] == 12'h000 && !outHiZ[1], "R4", "code 0", outSelect[23:12], 0);
    // R5 power down overrides stored select
    wrReg(8'h06, 8'h03, 8'h45, 1, "R5");
    chk(outSelect[24 +: 12] == '0 && outHiZ[2] && outGain[5:4] == 2'b10, "R5", "powered down",
        {outHiZ[2], outSelect[24 +: 12]}, {1'b1, 12'h0});
    // R6 outputs 1 and 9 share input 7
    wrReg(8'h06, 8'h01, 8'hE7, 1, "R6");
    wrReg(8'h06, 8'h09, 8'h87, 1, "R6");
    chk(outSelect[11:0] == 12'h040 && outSelect[96 +: 12] == 12'h040, "R6", "shared input",
        {outSelect[11:0], outSelect[96 +: 12]}, {12'h040, 12'h040});
    // R7 clamp registers, reserved bits ignored
    wrReg(8'h06, 8'h1D, 8'hA5, 1, "R7");
    wrReg(8'h06, 8'h1E, 8'hFA, 1, "R7");
    chk(clampMode == 12'hAA5, "R7", "clamp modes", clampMode, 12'hAA5);
    // R9 undefined indexes
    selSnap = outSelect;
    wrReg(8'h06, 8'h00, 8'hFF, 1, "R9");
    wrReg(8'h06, 8'h0A, 8'hFF, 1, "R9");
    wrReg(8'h06, 8'h1C, 8'hFF, 1, "R9");
    wrReg(8'h06, 8'h1F, 8'hFF, 1, "R9");
    chk(outSelect == selSnap && clampMode == 12'hAA5, "R9", "undefined writes",
        {outSelect, clampMode}, {selSnap, 12'hAA5});
    // R2 read direction and wrong address
    wrReg(8'h07, 8'h04, 8'h81, 0, "R2");
    wrReg(8'h86, 8'h04, 8'h81, 0, "R2");
    chk(!outEnable[3], "R2", "no write after nack", outEnable[3], 0);
    // R1 strap high
    addrSel = 1;
    wrReg(8'h06, 8'h04, 8'h82, 0, "R1");
    wrReg(8'h86, 8'h04, 8'h82, 1, "R1");
    chk(outSelect[36 +: 12] == 12'h002, "R1", "strap high write", outSelect[36 +: 12], 12'h002);
    addrSel = 0;
    // R13 ack waveform: no drive during address bits of a nacked byte
    curReq = "R13";
    startC();
    for (int i = 7; i >= 0; i--) begin
      sendBit(i == 0 ? 1'b0 : 1'b1);
      chk(!sdaDriveLow, "R13", "no drive in data bits", sdaDriveLow, 0);
    end
    sdaM = 1; waitQ(); sclM = 1; waitQ(); chk(!sdaDriveLow, "R13", "nack slot", sdaDriveLow, 0);
    waitQ(); sclM = 0; waitQ(); stopC();
    // R10 repeated START discards partial byte
    curReq = "R10";
    busy = 1;
    startC(); sendByte(8'h06, a); sendByte(8'h04, a);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    startC(); sendByte(8'h06, a); chk(a, "R10", "new address acked", a, 1);
    sendByte(8'h05, a); sendByte(8'h8B, a); stopC();
    modelWrite(8'h05, 8'h8B);
    busy = 0;
    waitQ();
    chk(outSelect[36 +: 12] == 12'h002 && outSelect[48 +: 12] == 12'h400, "R10",
        "partial discarded", {outSelect[36 +: 12], outSelect[48 +: 12]}, {12'h002, 12'h400});
    // R11 STOP mid byte, then bytes without START
    curReq = "R11";
    startC(); sendByte(8'h06, a); sendByte(8'h06, a);
    for (int i = 0; i < 5; i++) sendBit(1'b1);
    sclM = 0; waitQ(); stopC();
    sclM = 0; waitQ();
    sendByte(8'h06, a); chk(!a, "R11", "ignored after stop", a, 0);
    sendByte(8'h81, a); chk(!a, "R11", "ignored after stop", a, 0);
    sdaM = 1; sclM = 1; waitQ();
    chk(!outEnable[5], "R11", "no write", outEnable[5], 0);
    // R12 several data bytes hit the same register
    curReq = "R12";
    busy = 1;
    startC(); sendByte(8'h06, a); sendByte(8'h07, a);
    sendByte(8'h82, a); chk(a, "R12", "first data ack", a, 1);
    sendByte(8'h83, a); chk(a, "R12", "second data ack", a, 1);
    stopC();
    modelWrite(8'h07, 8'h83);
    busy = 0;
    waitQ();
    chk(outSelect[72 +: 12] == 12'h004 && outSelect[84 +: 12] == '0, "R12", "same register",
        {outSelect[72 +: 12], outSelect[84 +: 12]}, {12'h004, 12'h0});
    waitQ();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule